// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects an on-chip requester to an external asynchronous static RAM that holds 131,072 bytes (17 address bits, 8 data bits). A request arrives on a valid/ready handshake and carries an address, a write flag and write data. The block turns each request into the strobe sequence the memory expects. Chip enable, output enable and write enable are all active low. For a read, the captured byte comes back on a response bus together with a one-cycle valid pulse.

The memory's timing limits are parameters given in nanoseconds, together with the clock period. Each limit becomes a count of clock cycles: the limit divided by the period, rounded up, and never less than one. Writes are ended by write enable, and output enable stays high throughout a write. After every read the controller waits a bus-release interval before it may turn its data drivers on. This keeps the shared data bus from ever having two drivers. Between accesses, chip enable is high, so the memory sits in its low-power standby.

The data pad is split into three signals. An outgoing byte and a drive-enable go to the pad's tri-state buffer, and the pad's input value comes back in.

Top module: `sram_port_ctrl`

## Requirements
- R1: While the synchronous active-high reset is held, and in the first cycle after it, chip enable, output enable and write enable are all high, the data drive-enable is low, response valid is low and request ready is high.
- R2: A read holds chip enable and output enable low, with write enable high, for exactly RD_CYC consecutive cycles. The address stays stable throughout. RD_CYC is the larger of the cycle counts for the address-to-data time and the output-enable-to-data time.
- R3: At the end of the read window, the byte present on the data input is registered and appears on the response bus. Response valid is high for exactly one cycle, in the first cycle that output enable is high again.
- R4: A write drives chip enable low and keeps output enable high throughout. It has one setup cycle with the address and data already driven, then write enable low for exactly WP_CYC cycles, then one hold cycle with write enable high and the address and data unchanged.
- R5: The data drive-enable is never high while output enable is low.
- R6: After a read, output enable stays high for at least HZ_CYC cycles before the drive-enable can rise. HZ_CYC is the cycle count of the bus-release time.
- R7: Request ready is low in every cycle that chip enable is low. A request is taken only in a cycle where valid and ready are both high.
- R8: Whenever request ready is high, all three strobes are high and the drivers are off, so the idle memory is in standby.
- R9: Every limit is converted as ceil(ns / CLK_NS), with a minimum of 1. WP_CYC is the largest of the following: the pulse-width count, the data-setup count, the address-valid count minus one, and the write-cycle count minus two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Byte to write |
| rspValid | output | 1 | One-cycle pulse marking read data |
| rspData | output | DATA_W | Read data |
| sramCeN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramAddr | output | ADDR_W | Memory address |
| sramDqOut | output | DATA_W | Byte to the pad driver |
| sramDqOe | output | 1 | Pad driver enable, 1 = drive |
| sramDqIn | input | DATA_W | Byte from the pad |

## Verification
The case that matters is a read's response pulse falling in the same cycle as the bus turnaround that a write presented right behind it must wait for. The bench provokes this by placing a write request on the handshake immediately after a read is accepted, with valid held high, and doing so across the whole address range of a small configuration with a 4 ns clock. In that configuration RD_CYC is 3, WP_CYC is 2 and HZ_CYC is 2. A behavioural memory in the bench stores only what the strobes actually write. Cycle monitors measure each strobe window and the gap from output enable rising to drive-enable rising, and compare them with counts the bench computes from the nanosecond limits.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } ctlState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic loadReq;
    logic capRsp;
  } pinCtl_t;

  // nanoseconds to whole cycles, rounded up, at least one
  function automatic int nsToCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 1,
  parameter int WP_CYC = 1,
  parameter int HZ_CYC = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output pinCtl_t strb
);

  localparam int MAX_CYC = maxInt(maxInt(RD_CYC, WP_CYC), HZ_CYC);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  ctlState_t state, nextState;
  logic [CNT_W-1:0] cnt;
  logic lastRd, lastWp, lastHz;

  assign lastRd = (cnt == CNT_W'(RD_CYC - 1));
  assign lastWp = (cnt == CNT_W'(WP_CYC - 1));
  assign lastHz = (cnt == CNT_W'(HZ_CYC - 1));

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (reqValid) nextState = reqWrite ? ST_WR_SETUP : ST_RD_ACC;
      ST_RD_ACC:   if (lastRd) nextState = ST_RD_TURN;
      ST_RD_TURN:  if (lastHz) nextState = ST_IDLE;
      ST_WR_SETUP: nextState = ST_WR_PULSE;
      ST_WR_PULSE: if (lastWp) nextState = ST_WR_HOLD;
      ST_WR_HOLD:  nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) cnt <= '0;
      else                    cnt <= cnt + CNT_W'(1);
    end
  end

  // pin levels follow the state being entered, registered in the datapath
  always_comb begin
    strb.ceN     = (nextState == ST_IDLE) || (nextState == ST_RD_TURN);
    strb.oeN     = (nextState != ST_RD_ACC);
    strb.weN     = (nextState != ST_WR_PULSE);
    strb.drive   = (nextState == ST_WR_SETUP) || (nextState == ST_WR_PULSE) ||
                   (nextState == ST_WR_HOLD);
    strb.loadReq = (state == ST_IDLE) && reqValid;
    strb.capRsp  = (state == ST_RD_ACC) && lastRd;
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pinCtl_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe
);

  // strobes: reset to inactive
  always_ff @(posedge clk) begin
    if (rst) begin
      sramCeN  <= 1'b1;
      sramOeN  <= 1'b1;
      sramWeN  <= 1'b1;
      sramDqOe <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      sramCeN  <= strb.ceN;
      sramOeN  <= strb.oeN;
      sramWeN  <= strb.weN;
      sramDqOe <= strb.drive;
      rspValid <= strb.capRsp;
    end
  end

  // address and data hold through the whole access
  always_ff @(posedge clk) begin
    if (rst) begin
      sramAddr  <= '0;
      sramDqOut <= '0;
      rspData   <= '0;
    end else begin
      if (strb.loadReq) begin
        sramAddr  <= reqAddr;
        sramDqOut <= reqWdata;
      end
      if (strb.capRsp) rspData <= sramDqIn;
    end
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 10,
  parameter int T_DOE_NS  = 5,
  parameter int T_PWE_NS  = 7,
  parameter int T_SD_NS   = 5,
  parameter int T_AW_NS   = 7,
  parameter int T_WC_NS   = 10,
  parameter int T_HZOE_NS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int RD_CYC = maxInt(nsToCyc(T_AA_NS, CLK_NS), nsToCyc(T_DOE_NS, CLK_NS));
  localparam int WP_CYC = maxInt(maxInt(nsToCyc(T_PWE_NS, CLK_NS), nsToCyc(T_SD_NS, CLK_NS)),
                                 maxInt(maxInt(1, nsToCyc(T_AW_NS, CLK_NS) - 1),
                                        maxInt(1, nsToCyc(T_WC_NS, CLK_NS) - 2)));
  localparam int HZ_CYC = nsToCyc(T_HZOE_NS, CLK_NS);

  pinCtl_t strb;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC),
    .HZ_CYC(HZ_CYC)
  ) i_fsm (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .sramDqIn (sramDqIn),
    .rspValid (rspValid),
    .rspData  (rspData),
    .sramCeN  (sramCeN),
    .sramOeN  (sramOeN),
    .sramWeN  (sramWeN),
    .sramAddr (sramAddr),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_HZOE_NS = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rspValid,
  input logic              sramCeN,
  input logic              sramOeN,
  input logic              sramWeN,
  input logic [ADDR_W-1:0] sramAddr,
  input logic [DATA_W-1:0] sramDqOut,
  input logic              sramDqOe
);

  localparam int HZ_CYC = nsToCyc(T_HZOE_NS, CLK_NS);

  // cycles that output enable has been high, saturating
  logic [15:0] oeHighCnt;
  always_ff @(posedge clk) begin
    if (rst)             oeHighCnt <= 16'hFFFF;
    else if (!sramOeN)   oeHighCnt <= '0;
    else if (oeHighCnt != 16'hFFFF) oeHighCnt <= oeHighCnt + 16'd1;
  end

  // R5
  always @(posedge clk) begin
    if (!rst) drv_contention_chk: assert (!(sramDqOe && !sramOeN));
  end

  // R8
  standby_idle_chk: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (sramCeN && sramOeN && sramWeN && !sramDqOe));

  // R3
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  // R4
  wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !sramWeN |-> (!sramCeN && sramOeN && sramDqOe));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sramWeN) |-> ($stable(sramAddr) && $stable(sramDqOut) && sramDqOe && !sramCeN));

  // R2
  rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!sramOeN && $past(!sramOeN)) |-> $stable(sramAddr));

  // R6
  turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sramDqOe) |-> (oeHighCnt >= 16'(HZ_CYC)));

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !sramCeN |-> !reqReady);

endmodule

bind sram_port_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CLK_NS(CLK_NS),
  .T_HZOE_NS(T_HZOE_NS)
) i_chk (.*);

// File: tb/test_sram_port_ctrl.sv
`timescale 1ns/1ps
module test_sram_port_ctrl;

  localparam int CLK_PERIOD = 4;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  // expected counts from the nanosecond limits (R9)
  localparam int E_RD = 3;  // max(ceil(10/4), ceil(5/4))
  localparam int E_WP = 2;  // max(ceil(7/4), ceil(5/4), ceil(7/4)-1, ceil(10/4)-2)
  localparam int E_HZ = 2;  // ceil(5/4)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid, sramCeN, sramOeN, sramWeN, sramDqOe;
  logic [DW-1:0] rspData, sramDqOut, sramDqIn;
  logic [AW-1:0] sramAddr;

  int errors = 0;
  int checks = 0;
  bit monOn = 1'b0;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_port_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD),
    .T_AA_NS(10), .T_DOE_NS(5), .T_PWE_NS(7), .T_SD_NS(5),
    .T_AW_NS(7), .T_WC_NS(10), .T_HZOE_NS(5)
  ) i_sram_port_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .sramCeN(sramCeN),
    .sramOeN(sramOeN), .sramWeN(sramWeN), .sramAddr(sramAddr),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  // behavioural memory: answers only a proper read, stores only a proper write
  assign sramDqIn = (!sramCeN && !sramOeN && sramWeN) ? mem[sramAddr] : 8'hEE;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle monitors, sampled mid-cycle
  int rdRun = 0, lastRd = 0, weRun = 0, oeHigh = 100;
  logic pDqOe = 1'b0, pCeN = 1'b1, pWeN = 1'b1;
  logic [AW-1:0] pAddr = '0;
  logic [DW-1:0] pDq = '0;

  always @(negedge clk) begin
    if (monOn) begin
      if (!sramCeN && !sramWeN && sramDqOe) mem[sramAddr] = sramDqOut;
      // R2 read window length
      if (!sramCeN && !sramOeN && sramWeN) rdRun++;
      else if (rdRun > 0) begin
        check(rdRun == E_RD, "R2/R9 read window", rdRun, E_RD);
        lastRd = rdRun;
        rdRun = 0;
      end
      // R3 response pulse right after the read window
      if (rspValid) begin
        check(lastRd == E_RD && sramOeN, "R3 response timing", lastRd, E_RD);
        lastRd = 0;
        if (expQ.size() > 0) begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          check(rspData == e, "R3 read data", rspData, e);
        end else check(1'b0, "R3 unexpected response", 1, 0);
      end
      // R4 write pulse, setup and hold
      if (!sramWeN) begin
        if (pWeN) check(pDqOe && !pCeN && pAddr == sramAddr && pDq == sramDqOut,
                        "R4 setup cycle", pDqOe, 1);
        check(!sramCeN && sramOeN && sramDqOe, "R4 strobes in pulse", sramOeN, 1);
        weRun++;
      end else if (weRun > 0) begin
        check(weRun == E_WP, "R4/R9 write pulse", weRun, E_WP);
        check(sramDqOe && !sramCeN && pAddr == sramAddr && pDq == sramDqOut,
              "R4 hold cycle", sramDqOe, 1);
        weRun = 0;
      end
      // R5 no two drivers
      if (sramDqOe) check(sramOeN, "R5 drive with output enable low", sramOeN, 1);
      // R6 turnaround
      if (sramDqOe && !pDqOe) check(oeHigh >= E_HZ, "R6 turnaround", oeHigh, E_HZ);
      // R7 and R8
      if (!sramCeN) check(!reqReady, "R7 ready while busy", reqReady, 0);
      if (reqReady) check(sramCeN && sramOeN && sramWeN && !sramDqOe,
                          "R8 standby when idle", sramCeN, 1);
    end
    oeHigh = sramOeN ? oeHigh + 1 : 0;
    pDqOe = sramDqOe; pCeN = sramCeN; pWeN = sramWeN; pAddr = sramAddr; pDq = sramDqOut;
  end

  task automatic issue(input bit wr, input int a, input logic [DW-1:0] d);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(a); reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    if (!wr) expQ.push_back(shadow[a]);
    else shadow[a] = d;
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0 || !reqReady) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1 during reset
    check(sramCeN && sramOeN && sramWeN && !sramDqOe && !rspValid,
          "R1 reset strobes", {sramCeN, sramOeN, sramWeN, sramDqOe}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    check(reqReady && sramCeN && sramOeN && sramWeN && !sramDqOe && !rspValid,
          "R1 after reset", reqReady, 1);
    monOn = 1'b1;

    // pattern 1: arithmetic fill then read back
    for (int a = 0; a < DEPTH; a++) issue(1'b1, a, DW'((a * 37 + 5) & 8'hFF));
    drain();
    for (int a = 0; a < DEPTH; a++) issue(1'b0, a, '0);
    drain();

    // pattern 2: read immediately followed by write of the complement
    for (int a = 0; a < DEPTH; a++) begin
      issue(1'b0, a, '0);
      issue(1'b1, a, ~shadow[a]);
    end
    drain();
    for (int a = DEPTH - 1; a >= 0; a--) issue(1'b0, a, '0);
    drain();

    // pattern 3: back-to-back writes then alternating reads with valid held
    for (int a = 0; a < DEPTH; a += 3) issue(1'b1, a, DW'(a ^ 8'h5A));
    for (int a = 0; a < DEPTH; a += 2) issue(1'b0, a, '0);
    drain();

    check(expQ.size() == 0, "R3 all responses returned", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule